// File: doc/BRIEF.md
# Truncated Anti-Logarithm Converter

This block turns an approximate base-two logarithm back into a linear unsigned number. The logarithm arrives as an integer characteristic `char_in` and a short fraction `frac_in` of `FRAC_W` bits. The block uses the straight-line inverse 2^(k+f) ≈ 2^k·(1+f). It forms the word `{1'b1, frac_in}` and shifts it so that the implicit leading one lands on bit `k` of the result. Fraction bits that would fall below bit 0 are dropped, and every result bit below the shifted word is zero.

The result is `2*OP_W` bits wide. This lets the sum of two `OP_W`-bit logarithms (an approximate product) be converted back without loss of range. Only `FRAC_W + 1` bits enter the shifter, so the barrel shifter is far smaller than one that carries a full mantissa. Two cases are handled apart from the shift. A characteristic that would put the leading one above the top bit saturates the result and raises an overflow flag. A zero marker forces the result to zero. The block has two register stages: one for decode and one for the shift and select.

Top module: `antilog_trunc`

## Requirements
- R1: For FRAC_W <= k <= 2*OP_W-1 and zero_in low, z_out equals {1, frac_in} shifted left by k-FRAC_W. The leading one is at bit k, and all bits below bit k-FRAC_W are zero.
- R2: For k < FRAC_W and zero_in low, z_out equals {1, frac_in} shifted right by FRAC_W-k, dropping the fraction bits that fall below bit 0. With k = 0 the result is exactly 1.
- R3: The result is 2*OP_W bits wide. k = 2*OP_W-1 places the leading one on the MSB and ovf_out stays low.
- R4: For k > 2*OP_W-1 and zero_in low, z_out is all ones and ovf_out is 1.
- R5: With zero_in high, z_out is 0 and ovf_out is 0, whatever the values of char_in and frac_in.
- R6: valid_out is high exactly two cycles after a cycle with valid_in high. When no result is due, z_out and ovf_out hold their last values.
- R7: After synchronous reset, valid_out, z_out and ovf_out are all 0.
- R8: ovf_out is 1 only for results whose characteristic exceeded 2*OP_W-1 and whose zero_in was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Input operand is valid this cycle |
| zero_in | input | 1 | Operand represents zero; forces a zero result |
| char_in | input | CHAR_W | Integer part k of the logarithm (unsigned) |
| frac_in | input | FRAC_W | Truncated fraction bits of the logarithm |
| valid_out | output | 1 | Result is valid this cycle |
| z_out | output | 2*OP_W | Linear result |
| ovf_out | output | 1 | Result saturated because k was too large |

## Verification
The bench sweeps k across the boundary between right and left alignment (k = FRAC_W-1, FRAC_W, FRAC_W+1). An off-by-one in the alignment would move the leading one by one bit and double or halve every result. It drives k = 2*OP_W-1 and k = 2*OP_W. A wrong limit would either saturate a legal top-bit result or let the leading one fall off the word. Zero markers are sent with both legal and overflowing characteristics, so a wrong priority between zero and saturation would show as all ones or a raised flag. Idle gaps between operands check that the outputs hold and that the valid pipeline neither drops nor invents results.

// File: rtl/antilog_pkg.sv
package antilog_pkg;

  // What the output stage must produce for one operand.
  typedef enum logic [1:0] {
    RES_SHIFT = 2'd0,
    RES_ZERO  = 2'd1,
    RES_SAT   = 2'd2
  } res_kind_e;

endpackage

// File: rtl/antilog_decode.sv
module antilog_decode #(
  parameter int CHAR_W = 6,
  parameter int SH_W   = 5
) (
  input  logic                   zero_in,
  input  logic [CHAR_W-1:0]      char_in,
  output antilog_pkg::res_kind_e kind,
  output logic [SH_W-1:0]        shamt
);
  import antilog_pkg::*;

  logic too_big;

  // Any set bit above the shift range means the leading one would leave the word.
  generate
    if (CHAR_W > SH_W) begin : g_ovf
      assign too_big = |char_in[CHAR_W-1:SH_W];
    end else begin : g_no_ovf
      assign too_big = 1'b0;
    end
  endgenerate

  assign shamt = char_in[SH_W-1:0];

  // The zero marker wins over saturation.
  always_comb begin
    if (zero_in)      kind = RES_ZERO;
    else if (too_big) kind = RES_SAT;
    else              kind = RES_SHIFT;
  end

endmodule

// File: rtl/antilog_shifter.sv
module antilog_shifter #(
  parameter int FRAC_W = 4,
  parameter int OUT_W  = 32,
  parameter int SH_W   = 5
) (
  input  logic [FRAC_W-1:0] frac,
  input  logic [SH_W-1:0]   shamt,
  output logic [OUT_W-1:0]  shifted
);
  // The (FRAC_W+1)-bit word sits at the bottom of an extended vector.
  // Shifting it left by k and then dropping the low FRAC_W bits puts the
  // leading one at bit k. That one shift covers both right and left alignment.
  localparam int EXT_W = OUT_W + FRAC_W;

  logic [EXT_W-1:0] stage [SH_W+1];

  assign stage[0] = {{(EXT_W-FRAC_W-1){1'b0}}, 1'b1, frac};

  generate
    for (genvar i = 0; i < SH_W; i++) begin : g_stage
      assign stage[i+1] = shamt[i] ? (stage[i] << (1 << i)) : stage[i];
    end
  endgenerate

  assign shifted = stage[SH_W][EXT_W-1:FRAC_W];

endmodule

// File: rtl/antilog_select.sv
module antilog_select #(
  parameter int OUT_W = 32
) (
  input  antilog_pkg::res_kind_e kind,
  input  logic [OUT_W-1:0]       shifted,
  output logic [OUT_W-1:0]       res_z,
  output logic                   res_ovf
);
  import antilog_pkg::*;

  always_comb begin
    res_z   = shifted;
    res_ovf = 1'b0;
    case (kind)
      RES_ZERO: res_z = '0;
      RES_SAT: begin
        res_z   = '1;
        res_ovf = 1'b1;
      end
      default: res_z = shifted;
    endcase
  end

endmodule

// File: rtl/antilog_trunc.sv
module antilog_trunc #(
  parameter int OP_W   = 16,
  parameter int FRAC_W = 4,
  parameter int CHAR_W = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_in,
  input  logic                zero_in,
  input  logic [CHAR_W-1:0]   char_in,
  input  logic [FRAC_W-1:0]   frac_in,
  output logic                valid_out,
  output logic [2*OP_W-1:0]   z_out,
  output logic                ovf_out
);
  import antilog_pkg::*;

  localparam int OUT_W = 2 * OP_W;
  localparam int SH_W  = $clog2(OUT_W);

  // Stage 1: decode and register.
  res_kind_e        dec_kind;
  logic [SH_W-1:0]  dec_shamt;

  antilog_decode #(.CHAR_W(CHAR_W), .SH_W(SH_W)) u_decode (
    .zero_in (zero_in),
    .char_in (char_in),
    .kind    (dec_kind),
    .shamt   (dec_shamt)
  );

  logic              s1_valid;
  res_kind_e         s1_kind;
  logic [SH_W-1:0]   s1_shamt;
  logic [FRAC_W-1:0] s1_frac;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_kind  <= RES_ZERO;
      s1_shamt <= '0;
      s1_frac  <= '0;
    end else begin
      s1_valid <= valid_in;
      if (valid_in) begin
        s1_kind  <= dec_kind;
        s1_shamt <= dec_shamt;
        s1_frac  <= frac_in;
      end
    end
  end

  // Stage 2: shift, select and register outputs.
  logic [OUT_W-1:0] shifted;
  logic [OUT_W-1:0] res_z;
  logic             res_ovf;

  antilog_shifter #(.FRAC_W(FRAC_W), .OUT_W(OUT_W), .SH_W(SH_W)) u_shift (
    .frac    (s1_frac),
    .shamt   (s1_shamt),
    .shifted (shifted)
  );

  antilog_select #(.OUT_W(OUT_W)) u_select (
    .kind    (s1_kind),
    .shifted (shifted),
    .res_z   (res_z),
    .res_ovf (res_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      z_out     <= '0;
      ovf_out   <= 1'b0;
    end else begin
      valid_out <= s1_valid;
      if (s1_valid) begin
        z_out   <= res_z;
        ovf_out <= res_ovf;
      end
    end
  end

  // Assertions
  p_sat_r4: assert property (@(posedge clk) disable iff (rst)
    valid_out && ovf_out |-> (&z_out));

  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    valid_out && $past(valid_in, 2) && $past(zero_in, 2) |-> (z_out == '0) && !ovf_out);

  p_latency_r6: assert property (@(posedge clk) disable iff (rst)
    valid_out |-> $past(valid_in, 2));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> $stable(z_out) && $stable(ovf_out));

  p_bits_r1: assert property (@(posedge clk) disable iff (rst)
    valid_out && !ovf_out |-> ($countones(z_out) <= FRAC_W + 1));

  p_ovf_cause_r8: assert property (@(posedge clk) disable iff (rst)
    valid_out && ovf_out |-> ($past(char_in, 2) > CHAR_W'(OUT_W - 1)) && !$past(zero_in, 2));

endmodule

// File: tb/sim_antilog_trunc.sv
`timescale 1ns/1ps
module sim_antilog_trunc;
  localparam int OP_W   = 16;
  localparam int FRAC_W = 4;
  localparam int CHAR_W = 6;
  localparam int OUT_W  = 2 * OP_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              valid_in = 1'b0;
  logic              zero_in = 1'b0;
  logic [CHAR_W-1:0] char_in = '0;
  logic [FRAC_W-1:0] frac_in = '0;
  logic              valid_out;
  logic [OUT_W-1:0]  z_out;
  logic              ovf_out;

  always #5 clk = ~clk;

  antilog_trunc #(.OP_W(OP_W), .FRAC_W(FRAC_W), .CHAR_W(CHAR_W)) u0 (
    .clk, .rst, .valid_in, .zero_in, .char_in, .frac_in,
    .valid_out, .z_out, .ovf_out
  );

  int n_cmp = 0;
  int n_bad = 0;
  int n_push = 0;
  int n_pop = 0;
  bit done = 1'b0;

  logic [OUT_W-1:0] exp_z_q [$];
  logic             exp_o_q [$];
  string            exp_r_q [$];
  logic [OUT_W-1:0] last_z;
  logic             last_o;

  task automatic check(input string req, input logic [OUT_W:0] act, input logic [OUT_W:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  task automatic send(input int k, input int f, input bit z, input string req);
    logic [63:0] w;
    logic [OUT_W-1:0] ez;
    logic eo;
    @(negedge clk);
    valid_in = 1'b1;
    zero_in  = z;
    char_in  = CHAR_W'(k);
    frac_in  = FRAC_W'(f);
    w = 64'((1 << FRAC_W) | f);
    eo = 1'b0;
    if (z) ez = '0;
    else if (k > OUT_W - 1) begin
      ez = '1;
      eo = 1'b1;
    end else if (k >= FRAC_W) ez = OUT_W'(w << (k - FRAC_W));
    else ez = OUT_W'(w >> (FRAC_W - k));
    exp_z_q.push_back(ez);
    exp_o_q.push_back(eo);
    exp_r_q.push_back(req);
    last_z = ez;
    last_o = eo;
    n_push++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_in = 1'b0;
      char_in  = CHAR_W'(i * 7);
      frac_in  = FRAC_W'(i);
      zero_in  = i[0];
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && valid_out) begin
      if (exp_z_q.size() == 0) begin
        n_cmp++;
        n_bad++;
        $display("FAIL R6: actual unexpected result %h expected none", z_out);
      end else begin
        string r;
        logic [OUT_W-1:0] ez;
        logic eo;
        r  = exp_r_q.pop_front();
        ez = exp_z_q.pop_front();
        eo = exp_o_q.pop_front();
        n_pop++;
        check(r, {ovf_out, z_out}, {eo, ez});
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7", {valid_out, ovf_out, z_out[OUT_W-2:0]}, '0);
    check("R7", {1'b0, z_out}, '0);
    @(negedge clk);
    rst = 1'b0;

    // R2: right-aligned region, including k = 0 giving 1
    for (int k = 0; k < FRAC_W; k++) begin
      send(k, 4'hF, 1'b0, "R2");
      send(k, 4'h9, 1'b0, "R2");
    end
    send(0, 0, 1'b0, "R2");
    // R1: alignment boundary and left-shift sweep
    for (int k = FRAC_W; k < OUT_W - 1; k++) send(k, (k * 5) % 16, 1'b0, "R1");
    // R3: leading one on MSB
    send(OUT_W - 1, 4'hA, 1'b0, "R3");
    send(OUT_W - 1, 0, 1'b0, "R3");
    // R4 / R8: saturation
    send(OUT_W, 3, 1'b0, "R4");
    send(45, 4'hF, 1'b0, "R4");
    send(63, 0, 1'b0, "R8");
    // R8: a legal value right after overflow clears the flag
    send(OUT_W - 1, 1, 1'b0, "R8");
    // R5: zero marker with legal and overflowing characteristics
    send(9, 4'hF, 1'b1, "R5");
    send(63, 4'hF, 1'b1, "R5");
    send(0, 0, 1'b1, "R5");
    // R6: gaps between operands
    send(10, 6, 1'b0, "R6");
    idle(3);
    send(OUT_W, 2, 1'b0, "R6");
    idle(1);
    send(17, 4'hC, 1'b0, "R6");
    idle(6);
    // R6: outputs hold while idle
    check("R6", {valid_out, z_out}, {1'b0, last_z});
    check("R6", {{OUT_W{1'b0}}, ovf_out}, {{OUT_W{1'b0}}, last_o});
    check("R6", OUT_W'(n_pop), OUT_W'(n_push));
    done = 1'b1;
    finish_run();
  end

endmodule